// File: doc/BRIEF.md
# Thermostat Alert Unit with Consecutive-Fault Filter

This block watches the stream of finished temperature conversions and decides when a thermal alert is raised and dropped. Each result is compared, as a signed 12-bit two's-complement number, against a programmable upper limit and a programmable lower limit. A consecutive-fault filter demands a programmable run of qualifying results before anything changes, so a single noisy sample cannot flip the alert.

Two behaviours are selectable. In level-following (comparator) mode the alert tracks the temperature with hysteresis between the two limits. In latched (interrupt) mode each qualifying crossing raises the alert, which then stays up until software reads any register, wins an alert-response exchange on the bus, or puts the sensor to sleep; after each clear the block waits for the opposite crossing. The pin level has selectable polarity, and a status bit tells an alert-response handler which limit caused the alert. The register file and the bus engine sit outside and feed this block through strobes.

Top module: `thermo_alert`

## Requirements
- R1: The filter length is taken from `cfg_fq`: code 0 needs 1 qualifying conversion in a row, code 1 needs 2, code 2 needs 4, code 3 needs 6.
- R2: With `cfg_intr`=0 the alert becomes active once the run of results greater than or equal to `lim_hi` reaches the filter length, and becomes inactive once the run of results strictly below `lim_lo` reaches it; `alert_act` changes at the clock edge that samples the completing `conv_vld`.
- R3: A conversion that does not meet the condition being waited for, a change of `cfg_intr`, a general reset or an alert clear restarts the run from zero.
- R4: With `cfg_intr`=1 the alert becomes active, with `alert_status`=1, after a full run at or above `lim_hi`, and stays active, counting nothing, until a clear.
- R5: With `cfg_intr`=1, a `reg_rd` pulse, an `arw_won` pulse or `cfg_sleep`=1 clears the alert at the next edge; with `cfg_intr`=0 these inputs leave the alert unchanged.
- R6: In latched mode, after a high-limit alert is cleared the next alert needs a full run strictly below `lim_lo` and reports `alert_status`=0; after that one is cleared the block waits for the high limit again.
- R7: `alert_pin` equals `alert_act` when `cfg_pol`=1 and its inverse when `cfg_pol`=0, using `cfg_pol` and `alert_act` as they stand after the same clock edge.
- R8: A `gen_rst` pulse clears the alert, the status bit and the run count, and re-arms the high-limit check.
- R9: Comparisons use all 12 bits as signed values: 0xFFC (-0.25 degree) is below 0x004 and below 0x000.
- R10: After reset `alert_act`=0, `alert_status`=0 and `alert_pin`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_vld | input | 1 | One-cycle pulse: a new conversion result is on `conv_temp` |
| conv_temp | input | 12 | Conversion result, signed, 1/16 degree per LSB |
| lim_hi | input | 12 | Upper limit, same format |
| lim_lo | input | 12 | Lower limit, same format |
| cfg_intr | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| cfg_pol | input | 1 | 1 = pin active high, 0 = active low |
| cfg_fq | input | 2 | Filter length code |
| cfg_sleep | input | 1 | Shutdown level from the configuration |
| reg_rd | input | 1 | Pulse: any register was read |
| arw_won | input | 1 | Pulse: an alert-response exchange was won |
| gen_rst | input | 1 | Pulse: general-call reset |
| alert_pin | output | 1 | Alert pin level after polarity |
| alert_act | output | 1 | Alert active flag |
| alert_status | output | 1 | 1 = high-limit cause, 0 = low-limit cause |

## Verification
A wrong run count appears as an alert edge one or more conversions early or late, which the per-clock reference comparison catches at the first conversion that should or should not have completed the run. A wrong armed-limit state shows when a latched alert fires on the same limit twice in a row or reports the wrong status bit, visible at the next completing conversion after a clear. A polarity or clear fault is visible on `alert_pin` or `alert_act` one edge after the stimulus.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

  localparam int NEED_MAX = 6;

  typedef struct packed {
    logic act;
    logic seek_low;
    logic cause;
  } alert_st_t;

  function automatic logic [2:0] fq_need(input logic [1:0] code);
    case (code)
      2'd0:    fq_need = 3'd1;
      2'd1:    fq_need = 3'd2;
      2'd2:    fq_need = 3'd4;
      default: fq_need = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi,
  input  logic [TW-1:0] lo,
  output logic          at_hi,
  output logic          below_lo
);
  always_comb begin
    at_hi    = $signed(temp) >= $signed(hi);
    below_lo = $signed(temp) <  $signed(lo);
  end
endmodule

// File: rtl/ta_fault_filter.sv
module ta_fault_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             conv,
  input  logic             hit,
  input  logic [CNT_W-1:0] need,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt + CNT_W'(1);
    fire    = conv && hit && !clr && (cnt_inc == need);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (conv) begin
      if (!hit || fire) cnt <= '0;
      else              cnt <= cnt_inc;
    end
  end

  assert_miss_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (conv && !hit) |=> (cnt == '0));
  assert_clear_restart_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/ta_alert_state.sv
module ta_alert_state
  import thermo_alert_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      gen_rst,
  input  logic      intr,
  input  logic      clear_req,
  input  logic      fire,
  output alert_st_t st,
  output logic      act_nxt
);
  alert_st_t nxt;

  always_comb begin
    nxt = st;
    if (gen_rst) begin
      nxt = '0;
    end else if (clear_req) begin
      nxt.act = 1'b0;
    end else if (fire) begin
      if (!st.seek_low) begin
        nxt.act      = 1'b1;
        nxt.seek_low = 1'b1;
        nxt.cause    = 1'b1;
      end else begin
        nxt.act      = intr;
        nxt.seek_low = 1'b0;
        nxt.cause    = 1'b0;
      end
    end
    act_nxt = nxt.act;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= nxt;
  end

  assert_gen_clear_R8: assert property (@(posedge clk) disable iff (rst)
    gen_rst |=> (!st.act && !st.seek_low && !st.cause));
  assert_intr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clear_req && !gen_rst) |=> !st.act);
  assert_latched_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (intr && st.act && !clear_req && !gen_rst) |=> st.act);

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_vld,
  input  logic [TW-1:0] conv_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic          cfg_intr,
  input  logic          cfg_pol,
  input  logic [1:0]    cfg_fq,
  input  logic          cfg_sleep,
  input  logic          reg_rd,
  input  logic          arw_won,
  input  logic          gen_rst,
  output logic          alert_pin,
  output logic          alert_act,
  output logic          alert_status
);
  localparam int CNT_W = $clog2(NEED_MAX + 1);

  alert_st_t        st;
  logic             act_nxt;
  logic             at_hi, below_lo, hit;
  logic             intr_q, mode_chg, clear_req, hold, cnt_clr, conv_eff, fire;
  logic [CNT_W-1:0] need;
  logic             pin_q, ok_q;

  always_comb begin
    need      = CNT_W'(fq_need(cfg_fq));
    mode_chg  = cfg_intr != intr_q;
    clear_req = cfg_intr && (reg_rd || arw_won || cfg_sleep);
    hold      = cfg_intr && st.act;
    cnt_clr   = gen_rst || clear_req || mode_chg || hold;
    conv_eff  = conv_vld && !cnt_clr;
    hit       = st.seek_low ? below_lo : at_hi;
  end

  ta_limit_cmp #(.TW(TW)) u_cmp (
    .temp(conv_temp), .hi(lim_hi), .lo(lim_lo),
    .at_hi(at_hi), .below_lo(below_lo)
  );

  ta_fault_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .conv(conv_eff),
    .hit(hit), .need(need), .fire(fire)
  );

  ta_alert_state u_state (
    .clk(clk), .rst(rst), .gen_rst(gen_rst), .intr(cfg_intr),
    .clear_req(clear_req), .fire(fire), .st(st), .act_nxt(act_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_q <= 1'b0;
      pin_q  <= 1'b1;
      ok_q   <= 1'b0;
    end else begin
      intr_q <= cfg_intr;
      pin_q  <= ~(cfg_pol ^ act_nxt);
      ok_q   <= 1'b1;
    end
  end

  assign alert_pin    = pin_q;
  assign alert_act    = st.act;
  assign alert_status = st.cause;

  assert_pin_level_R7: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (alert_pin == ~($past(cfg_pol) ^ alert_act)));
  assert_rise_on_conv_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_act) |-> $past(conv_vld));
  assert_cmp_ignores_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_intr && !intr_q && alert_act && !conv_vld && !gen_rst) |=> alert_act);

endmodule

// File: tb/sim_thermo_alert.sv
module sim_thermo_alert;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_vld = 1'b0;
  logic [11:0] conv_temp = '0;
  logic [11:0] lim_hi = 12'h500;
  logic [11:0] lim_lo = 12'h4B0;
  logic        cfg_intr = 1'b0, cfg_pol = 1'b0, cfg_sleep = 1'b0;
  logic [1:0]  cfg_fq = 2'd0;
  logic        reg_rd = 1'b0, arw_won = 1'b0, gen_rst = 1'b0;
  logic        alert_pin, alert_act, alert_status;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R10";

  thermo_alert u0 (
    .clk(clk), .rst(rst), .conv_vld(conv_vld), .conv_temp(conv_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .cfg_intr(cfg_intr), .cfg_pol(cfg_pol),
    .cfg_fq(cfg_fq), .cfg_sleep(cfg_sleep), .reg_rd(reg_rd), .arw_won(arw_won),
    .gen_rst(gen_rst), .alert_pin(alert_pin), .alert_act(alert_act),
    .alert_status(alert_status)
  );

  always #2 clk = ~clk;

  // Behavioural reference
  int m_cnt = 0;
  bit m_act = 0, m_seek = 0, m_cause = 0, m_pin = 1, m_tm_prev = 0;

  function automatic int sx(input logic [11:0] v);
    return v[11] ? int'(v) - 4096 : int'(v);
  endfunction

  function automatic int need_of(input logic [1:0] c);
    int tbl[4] = '{1, 2, 4, 6};
    return tbl[c];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit clr, met, fired;
    if (rst) begin
      m_cnt = 0; m_act = 0; m_seek = 0; m_cause = 0; m_pin = 1; m_tm_prev = 0;
    end else begin
      clr   = gen_rst || (cfg_intr && (reg_rd || arw_won || cfg_sleep));
      fired = 0;
      if (clr || (cfg_intr != m_tm_prev) || (cfg_intr && m_act)) m_cnt = 0;
      else if (conv_vld) begin
        met = m_seek ? (sx(conv_temp) < sx(lim_lo)) : (sx(conv_temp) >= sx(lim_hi));
        if (met) begin
          m_cnt++;
          if (m_cnt == need_of(cfg_fq)) begin fired = 1; m_cnt = 0; end
        end else m_cnt = 0;
      end
      if (gen_rst) begin m_act = 0; m_seek = 0; m_cause = 0; end
      else if (clr) m_act = 0;
      else if (fired) begin
        if (!m_seek) begin m_act = 1; m_seek = 1; m_cause = 1; end
        else begin m_act = cfg_intr; m_seek = 0; m_cause = 0; end
      end
      m_pin = cfg_pol ? m_act : !m_act;
      m_tm_prev = cfg_intr;
    end
    #1;
    check(alert_act == m_act, cur_req, "alert_act", alert_act, m_act);
    check(alert_pin == m_pin, cur_req, "alert_pin", alert_pin, m_pin);
    check(alert_status == m_cause, cur_req, "alert_status", alert_status, m_cause);
  end

  task automatic conv(input logic [11:0] t);
    @(negedge clk); conv_vld = 1'b1; conv_temp = t;
    @(negedge clk); conv_vld = 1'b0;
  endtask

  task automatic convn(input logic [11:0] t, input int n);
    for (int i = 0; i < n; i++) conv(t);
  endtask

  task automatic expect_out(input bit a, input bit s, input string req);
    check(alert_act == a, req, "alert_act (directed)", alert_act, a);
    check(alert_status == s, req, "alert_status (directed)", alert_status, s);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R10";
    expect_out(0, 0, "R10");
    check(alert_pin == 1'b1, "R10", "alert_pin", alert_pin, 1);

    // R2 single-sample filter, equal counts as reaching
    cur_req = "R2";
    conv(12'h500); expect_out(1, 1, "R2");
    conv(12'h4B0); expect_out(1, 1, "R2");
    conv(12'h4AF); expect_out(0, 0, "R2");

    // R1 length two, with an interrupted run (R3)
    cur_req = "R1"; cfg_fq = 2'd1;
    conv(12'h600); conv(12'h100); conv(12'h600); expect_out(0, 0, "R3");
    conv(12'h600); expect_out(1, 1, "R1");
    convn(12'h100, 2); expect_out(0, 0, "R1");

    // R1 length six
    cfg_fq = 2'd3;
    convn(12'h600, 5); expect_out(0, 0, "R1");
    conv(12'h600); expect_out(1, 1, "R1");
    convn(12'h000, 5); expect_out(1, 1, "R1");
    conv(12'h000); expect_out(0, 0, "R1");

    // R3 mode change restarts the run, length four
    cur_req = "R3"; cfg_fq = 2'd2;
    convn(12'h600, 2);
    @(negedge clk); cfg_intr = 1'b1;
    @(negedge clk); cfg_intr = 1'b0;
    @(negedge clk);
    convn(12'h600, 3); expect_out(0, 0, "R3");
    conv(12'h600); expect_out(1, 1, "R3");

    // R5 comparator mode ignores read, won and sleep
    cur_req = "R5";
    @(negedge clk); reg_rd = 1'b1; arw_won = 1'b1; cfg_sleep = 1'b1;
    @(negedge clk); reg_rd = 1'b0; arw_won = 1'b0; cfg_sleep = 1'b0;
    expect_out(1, 1, "R5");
    convn(12'h100, 4); expect_out(0, 0, "R2");

    // R9 signed full-width compare
    cur_req = "R9"; cfg_fq = 2'd0; lim_hi = 12'h004; lim_lo = 12'h000;
    conv(12'hFFC); expect_out(0, 0, "R9");
    conv(12'h004); expect_out(1, 1, "R9");
    conv(12'hFFC); expect_out(0, 0, "R9");

    // R4 latched mode
    cur_req = "R4"; lim_hi = 12'h500; lim_lo = 12'h4B0; cfg_fq = 2'd1;
    @(negedge clk); cfg_intr = 1'b1;
    @(negedge clk);
    convn(12'h500, 2); expect_out(1, 1, "R4");
    convn(12'h100, 3); expect_out(1, 1, "R4");

    // R5 read clears, R6 low-limit event next
    cur_req = "R5";
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    expect_out(0, 1, "R5");
    cur_req = "R6";
    conv(12'h100); expect_out(0, 1, "R6");
    conv(12'h100); expect_out(1, 0, "R6");
    cur_req = "R5";
    @(negedge clk); arw_won = 1'b1;
    @(negedge clk); arw_won = 1'b0;
    expect_out(0, 0, "R5");
    cur_req = "R6";
    convn(12'h100, 2); expect_out(0, 0, "R6");
    convn(12'h600, 2); expect_out(1, 1, "R6");
    cur_req = "R5";
    @(negedge clk); cfg_sleep = 1'b1;
    @(negedge clk); cfg_sleep = 1'b0;
    expect_out(0, 1, "R5");
    convn(12'h100, 2); expect_out(1, 0, "R6");

    // R7 polarity
    cur_req = "R7";
    @(negedge clk); cfg_pol = 1'b1;
    @(negedge clk);
    check(alert_pin == 1'b1, "R7", "alert_pin pol=1", alert_pin, 1);
    cfg_pol = 1'b0;
    @(negedge clk);
    check(alert_pin == 1'b0, "R7", "alert_pin pol=0", alert_pin, 0);

    // R8 general reset
    cur_req = "R8";
    @(negedge clk); gen_rst = 1'b1;
    @(negedge clk); gen_rst = 1'b0;
    expect_out(0, 0, "R8");
    convn(12'h100, 2); expect_out(0, 0, "R8");
    convn(12'h600, 2); expect_out(1, 1, "R8");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule